// File: doc/BRIEF.md
# Interrupt Source Routing Matrix

This block steers eight peripheral interrupt requests onto a sixteen-line legacy IRQ bus. The eight sources are two serial ports, a parallel port, a disk channel and four PCI-style INTx inputs. Each source carries a 4-bit line number in a small register file. The value zero leaves the source unconnected. Sources that land on the same line are OR-combined. Each line is then conditioned for either level or edge operation before it leaves for the downstream interrupt controller.

Configuration arrives on a 32-bit write port. The port has a byte address and four byte-lane enables. The byte at lane j of the addressed word is stored at byte index (word x 4 + j). Bytes 0 and 1 form the trigger-mode register, with one bit per line. Bytes 4 to 7 hold the routing nibbles. Bytes 2 and 3 are unused and store nothing.

Each line has its own three-state conditioner. The states are LN_IDLE (the combined request was low), LN_PULSE (the combined request has just risen) and LN_HELD (the request is still high after its pulse). The transitions are:
- RISE: LN_IDLE to LN_PULSE when the request is high.
- HOLD: LN_PULSE to LN_HELD while the request stays high.
- DROP: LN_PULSE or LN_HELD to LN_IDLE when the request is low.

An edge-mode line drives high only in LN_PULSE. A level-mode line drives high in any state other than LN_IDLE.

Top module: `irq_route_matrix`

## Requirements
- R1: While reset is asserted, and after it is released with no configuration written, all 16 IRQ outputs are low whatever the source inputs do. Reset clears every routing nibble and every trigger bit.
- R2: Routing byte 4 holds source 0 (serial port 1) in bits 3:0 and source 1 (serial port 2) in bits 7:4. Byte 5 holds source 2 (parallel port) in its low nibble and source 3 (disk channel) in its high nibble. Byte 6 holds sources 4 and 5, and byte 7 holds sources 6 and 7 (INTx A to D), in the same low-then-high order. A nibble value n in 1..15 sends that source to line n.
- R3: A routing nibble of zero disconnects its source from every line, so line 0 never asserts.
- R4: The combined request of a line is the logical OR of all active sources whose nibble selects that line.
- R5: Trigger bit k lives in byte 0 bit k for lines 0 to 7, and in byte 1 bit (k-8) for lines 8 to 15. A set bit selects level mode and a clear bit selects edge mode.
- R6: In level mode, an output equals its line's combined request from the previous clock cycle, including when the request falls.
- R7: In edge mode, a rising combined request produces exactly one high output cycle, one cycle after the rise. The output then stays low for as long as the request is held high.
- R8: A write updates only the bytes whose lane enable is set. Lane j carries wdata bits 8j+7 to 8j to byte index (address bits 2 and up) x 4 + j. All other bytes keep their contents.
- R9: Writes to bytes 2 and 3 change neither the trigger modes nor the routing.
- R10: Take the setup with trigger bytes 0x22 and 0x00 and routing bytes 0x34, 0x57, 0x00, 0x10. It sends serial 1 to line 4, serial 2 to line 3, parallel to line 7, disk to line 5 and INTx D to line 1. Lines 1 and 5 are level and the others are edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Byte address of the write; bits 1:0 are ignored |
| cfg_wdata | input | 32 | Write data, byte lane j in bits 8j+7:8j |
| cfg_be | input | 4 | Per-lane byte enables |
| src_req | input | 8 | Source requests: serial 1, serial 2, parallel, disk, INTx A..D |
| irq_out | output | 16 | Conditioned IRQ lines to the interrupt controller |

## Verification
Some properties are checked on every cycle:
- Line 0 never asserts.
- No line's request rises without an active source.
- A level-mode output tracks the previous cycle's combined request.
- An edge-mode output is high for one cycle only, and only after a high request.

Other behaviour only the bench's scenarios can show:
- The exact nibble and byte layout.
- The effect of lane enables and of the unused bytes.
- The OR of shared lines against a computed mapping.
- The reference setup as a whole.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Per-line conditioner states
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_PULSE = 2'd1,
        LN_HELD  = 2'd2
    } line_state_e;

    // Width of a routing nibble for a given line count
    function automatic int unsigned sel_width(input int unsigned lines);
        return $clog2(lines);
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_IRQ = 16,
    parameter int unsigned CFG_AW  = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [CFG_AW-1:0]                  cfg_addr,
    input  logic [31:0]                        cfg_wdata,
    input  logic [3:0]                         cfg_be,
    output logic [NUM_IRQ-1:0]                 trig_level,
    output logic [NUM_SRC*sel_width(NUM_IRQ)-1:0] route_map
);

    localparam int unsigned SEL_W       = sel_width(NUM_IRQ);
    localparam int unsigned TRIG_BYTES  = (NUM_IRQ + 7) / 8;
    localparam int unsigned ROUTE_BASE  = 4 * ((TRIG_BYTES + 3) / 4);
    localparam int unsigned ROUTE_BYTES = (NUM_SRC * SEL_W + 7) / 8;
    localparam int unsigned TOTAL_BYTES = ROUTE_BASE + ROUTE_BYTES;
    localparam int unsigned WORD_W      = CFG_AW - 2;

    logic [TOTAL_BYTES*8-1:0] cfg_q;

    for (genvar b = 0; b < TOTAL_BYTES; b++) begin : g_byte
        if ((b < TRIG_BYTES) || (b >= ROUTE_BASE)) begin : g_stored
            logic hit;
            assign hit = cfg_we && cfg_be[b % 4] &&
                         (cfg_addr[CFG_AW-1:2] == WORD_W'(b / 4));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[b*8 +: 8] <= 8'h00;
                end else if (hit) begin
                    cfg_q[b*8 +: 8] <= cfg_wdata[(b % 4)*8 +: 8];
                end
            end
        end else begin : g_gap
            assign cfg_q[b*8 +: 8] = 8'h00;
        end
    end

    assign trig_level = cfg_q[NUM_IRQ-1:0];
    assign route_map  = cfg_q[ROUTE_BASE*8 +: NUM_SRC*SEL_W];

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_IRQ = 16
) (
    input  logic [NUM_SRC-1:0]                    src_req,
    input  logic [NUM_SRC*sel_width(NUM_IRQ)-1:0] route_map,
    output logic [NUM_IRQ-1:0]                    line_req
);

    localparam int unsigned SEL_W = sel_width(NUM_IRQ);

    // Line 0 is the "disconnected" code and is never driven
    assign line_req[0] = 1'b0;

    for (genvar l = 1; l < NUM_IRQ; l++) begin : g_line
        logic [NUM_SRC-1:0] hit;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign hit[s] = src_req[s] &&
                            (route_map[s*SEL_W +: SEL_W] == SEL_W'(l));
        end
        assign line_req[l] = |hit;
    end

endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic level_mode,
    output logic irq
);

    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE:  if (req)  state_d = LN_PULSE;
            LN_PULSE: state_d = req ? LN_HELD : LN_IDLE;
            LN_HELD:  if (!req) state_d = LN_IDLE;
            default:  state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            LN_IDLE:  irq = 1'b0;
            LN_PULSE: irq = 1'b1;
            LN_HELD:  irq = level_mode;
            default:  irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_IRQ = 16,
    parameter int unsigned CFG_AW  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic [3:0]         cfg_be,
    input  logic [NUM_SRC-1:0] src_req,
    output logic [NUM_IRQ-1:0] irq_out
);

    localparam int unsigned SEL_W = sel_width(NUM_IRQ);

    logic [NUM_IRQ-1:0]       trig_level;
    logic [NUM_SRC*SEL_W-1:0] route_map;
    logic [NUM_IRQ-1:0]       line_req;

    irq_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_IRQ (NUM_IRQ),
        .CFG_AW  (CFG_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_be     (cfg_be),
        .trig_level (trig_level),
        .route_map  (route_map)
    );

    irq_src_router #(
        .NUM_SRC (NUM_SRC),
        .NUM_IRQ (NUM_IRQ)
    ) u_router (
        .src_req   (src_req),
        .route_map (route_map),
        .line_req  (line_req)
    );

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_cond
        irq_line_cond u_cond (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (line_req[k]),
            .level_mode (trig_level[k]),
            .irq        (irq_out[k])
        );
    end

endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_IRQ = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_req,
    input logic [NUM_IRQ-1:0] line_req,
    input logic [NUM_IRQ-1:0] trig_level,
    input logic [NUM_IRQ-1:0] irq_out
);

    AST_LINE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out[0]); // R3

    AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_req) |-> (|src_req)); // R4

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line_chk
        AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            trig_level[k] |-> (irq_out[k] == $past(line_req[k]))); // R6

        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_level[k] && irq_out[k]) |=> (trig_level[k] || !irq_out[k])); // R7

        AST_EDGE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_level[k] && irq_out[k]) |-> $past(line_req[k])); // R7
    end

endmodule

bind irq_route_matrix irq_route_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_IRQ (NUM_IRQ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .line_req   (line_req),
    .trig_level (trig_level),
    .irq_out    (irq_out)
);

// File: tb/irq_route_matrix_test.sv
module irq_route_matrix_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic [31:0] route;
        logic [15:0] trig;
        logic [7:0]  src;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0021, 16'hFFFF, 8'h03},  // R2 R6: separate lines, level
        '{32'h0000_0021, 16'h0000, 8'h01},  // R7: edge pulse
        '{32'h5555_5555, 16'h0020, 8'h81},  // R4: all share line 5
        '{32'h1000_5734, 16'h0022, 8'hFF},  // R10: reference setup
        '{32'hFEDC_BA98, 16'hAAAA, 8'hA5},  // R2 R5: upper lines, mixed modes
        '{32'h0000_0000, 16'hFFFF, 8'hFF}   // R3: all disconnected
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [7:0]  src_req = '0;
    logic [15:0] irq_out;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_matrix uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_be    (cfg_be),
        .src_req   (src_req),
        .irq_out   (irq_out)
    );

    function automatic logic [15:0] model_req(input logic [31:0] route, input logic [7:0] src);
        logic [15:0] r = '0;
        for (int s = 0; s < 8; s++) begin
            logic [3:0] n = route[s*4 +: 4];
            if (src[s] && n != 4'd0) r[n] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
    endtask

    task automatic quiet();
        @(negedge clk);
        src_req = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] e;
        // R1: outputs low during reset with all sources active
        src_req = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 in reset", irq_out, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after reset, unrouted", irq_out, 16'h0000);
        quiet();

        // Table walk: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NVEC; i++) begin
            cfg_write(3'd0, {16'h0000, VECS[i].trig}, 4'b0011);
            cfg_write(3'd4, VECS[i].route, 4'b1111);
            quiet();
            e = model_req(VECS[i].route, VECS[i].src);
            src_req = VECS[i].src;
            @(negedge clk);
            check($sformatf("R2 R4 R10 vec%0d first cycle", i), irq_out, e);
            @(negedge clk);
            check($sformatf("R5 R7 vec%0d held cycle", i), irq_out, e & VECS[i].trig);
            src_req = '0;
            @(negedge clk);
            check($sformatf("R6 vec%0d after drop", i), irq_out, 16'h0000);
        end

        // R7: held request gives a single pulse on an edge line
        cfg_write(3'd0, 32'h0, 4'b0011);
        cfg_write(3'd4, 32'h0000_0003, 4'b1111);
        quiet();
        src_req = 8'h01;
        @(negedge clk);
        check("R7 pulse", irq_out, 16'h0008);
        e = 16'h0000;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            e |= irq_out;
        end
        check("R7 no repeat while held", e, 16'h0000);
        quiet();

        // R8: byte enables keep other lanes
        cfg_write(3'd0, 32'h0000_FFFF, 4'b0011);
        cfg_write(3'd4, 32'h2222_2222, 4'b1111);
        cfg_write(3'd4, 32'h1111_1111, 4'b0100);
        src_req = 8'h30;
        @(negedge clk); @(negedge clk);
        check("R8 enabled lane updated", irq_out, 16'h0002);
        src_req = 8'hCF;
        @(negedge clk); @(negedge clk);
        check("R8 disabled lanes kept", irq_out, 16'h0004);

        // R9: unused bytes 2,3 do not touch trigger modes
        cfg_write(3'd0, 32'h0000_0000, 4'b1100);
        cfg_write(3'd2, 32'hFFFF_FFFF, 4'b1100);
        @(negedge clk);
        check("R9 level still on line 2", irq_out, 16'h0004);
        quiet();

        // R5: clearing only byte 1 makes upper lines edge
        cfg_write(3'd0, 32'h0000_0000, 4'b0010);
        cfg_write(3'd4, 32'h9999_9999, 4'b1111);
        quiet();
        src_req = 8'h01;
        @(negedge clk);
        check("R5 line 9 pulse", irq_out, 16'h0200);
        @(negedge clk);
        check("R5 line 9 edge mode", irq_out, 16'h0000);
        cfg_write(3'd4, 32'h0000_0004, 4'b0001);
        @(negedge clk);
        check("R5 line 4 still level", irq_out, 16'h0010);
        quiet();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule